// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads two entries from a page table kept in memory. A request carries the virtual address. The top ten bits pick an entry in a directory whose start address sits in a software-writable base register. That entry names the frame that holds a second-level table. The middle ten bits pick an entry in that table, and that entry names the physical frame. The low twelve bits pass through unchanged as the offset within a 4 KiB page. Each entry is a 32-bit word. The frame number sits in bits [31:12] and the valid flag in bit 0.

Memory is reached through a single-beat read port. A request is held with its address until the memory accepts it. The walker then waits for one response word. Only one read is ever outstanding. A directory entry with a clear valid flag means the whole second-level table is absent, so the walk stops with a fault and makes no second read. A second-level entry with a clear valid flag also ends the walk with a fault. A completed walk raises `done` for one cycle. `fault` qualifies that pulse, and `paddr` carries the result.

The controller has five named states. Idle waits for a request. Directory-request drives the first read. Directory-wait takes the first word. Table-request drives the second read. Table-wait takes the second word. The transitions are:
- Accept: Idle to Directory-request when `req_valid` is high.
- Dir-issued: Directory-request to Directory-wait when `mem_req_ready` is high.
- Dir-hit: Directory-wait to Table-request on a response with bit 0 set.
- Dir-miss: Directory-wait to Idle with a fault on a response with bit 0 clear.
- Table-issued: Table-request to Table-wait when `mem_req_ready` is high.
- Finish: Table-wait to Idle on any response, with a fault when bit 0 is clear.

Top module: `ptw_walker`

## Requirements
- R1: The virtual address splits into a directory index in bits [31:22], a table index in bits [21:12] and an offset in bits [11:0]. The first read of a walk goes to base + directory index * 4.
- R2: The second read goes to {directory entry bits [31:12], 12'h000} + table index * 4.
- R3: A directory entry with bit 0 clear ends the walk with `done`=1 and `fault`=1 after exactly one memory read.
- R4: A second-level entry with bit 0 clear ends the walk with `done`=1 and `fault`=1 after exactly two memory reads.
- R5: A successful walk makes exactly two reads. It ends with `done`=1, `fault`=0 and `paddr` = {second-level entry bits [31:12], virtual address bits [11:0]}.
- R6: `done` is high for exactly one cycle per walk. `fault` is high only together with `done`, and `paddr` reads 0 in a fault cycle.
- R7: `req_ready` is high only in Idle. A `req_valid` raised while a walk is in progress is ignored and does not change that walk's reads or result.
- R8: The base register resets to 0 and loads `base_wr_data` when `base_wr_en` is high. A walk uses the base value held when it was accepted. A write in the same cycle as an acceptance therefore affects only later walks.
- R9: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. No new read is issued while a response is still owed.
- R10: After reset the walker is idle: `req_ready`=1, and `mem_req_valid`, `done` and `fault` are all 0.
- R11: A new request is accepted in the same cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Load the directory base register |
| base_wr_data | input | 32 | New directory base address |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word read from memory |
| done | output | 1 | One-cycle walk completion pulse |
| fault | output | 1 | Completion is a page fault |
| paddr | output | 32 | Translated physical address (0 on fault) |

## Verification
Two events can fall in the same cycle. The first pair is a base-register write and the acceptance of a request. The bench raises both on one edge and checks that the first read address is built from the old base while the next walk uses the new one. The second pair is a completion pulse and a new acceptance. Requests are raised back to back in the cycle where `done` is high, and the bench checks that the following walk's reads and result are still correct. The sweeps run every directory index under a fixed memory image with zero latency and always-ready memory. A second sweep adds latency and a toggling ready. Expected addresses, fault kinds, read counts and results are computed arithmetically from that image.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_SEC_REQ,
        ST_SEC_WAIT
    } walk_state_t;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 10,
    parameter int PTE_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] table_base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int PAD_W = ADDR_W - IDX_W - PTE_SHIFT;

    // Scale the index by the entry size and offset from the table start
    assign entry_addr = table_base + {{PAD_W{1'b0}}, index, {PTE_SHIFT{1'b0}}};
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0]       entry,
    output logic [ADDR_W-OFF_W-1:0] frame,
    output logic                    present
);
    assign frame   = entry[ADDR_W-1:OFF_W];
    assign present = entry[0];
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DIR_BITS  = 10,
    parameter int SEC_BITS  = 10,
    parameter int PTE_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr_en,
    input  logic [ADDR_W-1:0] base_wr_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              req_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              done,
    output logic              fault,
    output logic [ADDR_W-1:0] paddr
);
    localparam int OFF_BITS  = ADDR_W - DIR_BITS - SEC_BITS;
    localparam int FRAME_W   = ADDR_W - OFF_BITS;
    localparam int PTE_SHIFT = $clog2(PTE_BYTES);

    walk_state_t state_q, state_d;

    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  walk_base_q;
    logic [ADDR_W-1:0]  vaddr_q;
    logic [FRAME_W-1:0] dir_frame_q;
    logic               done_q, fault_q;
    logic [ADDR_W-1:0]  paddr_q;

    logic [ADDR_W-1:0]  dir_entry_addr, sec_entry_addr, sec_table_base;
    logic [FRAME_W-1:0] rsp_frame;
    logic               rsp_present;
    logic               accept;

    assign accept         = (state_q == ST_IDLE) && req_valid;
    assign sec_table_base = {dir_frame_q, {OFF_BITS{1'b0}}};

    ptw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(DIR_BITS), .PTE_SHIFT(PTE_SHIFT)) dir_addr_i (
        .table_base (walk_base_q),
        .index      (vaddr_q[ADDR_W-1 -: DIR_BITS]),
        .entry_addr (dir_entry_addr)
    );

    ptw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(SEC_BITS), .PTE_SHIFT(PTE_SHIFT)) sec_addr_i (
        .table_base (sec_table_base),
        .index      (vaddr_q[OFF_BITS +: SEC_BITS]),
        .entry_addr (sec_entry_addr)
    );

    ptw_entry_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_BITS)) rsp_dec_i (
        .entry   (mem_rsp_data),
        .frame   (rsp_frame),
        .present (rsp_present)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid)     state_d = ST_DIR_REQ;
            ST_DIR_REQ:  if (mem_req_ready) state_d = ST_DIR_WAIT;
            ST_DIR_WAIT: if (mem_rsp_valid) state_d = rsp_present ? ST_SEC_REQ : ST_IDLE;
            ST_SEC_REQ:  if (mem_req_ready) state_d = ST_SEC_WAIT;
            ST_SEC_WAIT: if (mem_rsp_valid) state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // Walk context and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q      <= '0;
            walk_base_q <= '0;
            vaddr_q     <= '0;
            dir_frame_q <= '0;
            done_q      <= 1'b0;
            fault_q     <= 1'b0;
            paddr_q     <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            if (base_wr_en) base_q <= base_wr_data;
            if (accept) begin
                vaddr_q     <= req_vaddr;
                walk_base_q <= base_q;
            end
            if (state_q == ST_DIR_WAIT && mem_rsp_valid) begin
                dir_frame_q <= rsp_frame;
                if (!rsp_present) begin
                    done_q  <= 1'b1;
                    fault_q <= 1'b1;
                    paddr_q <= '0;
                end
            end
            if (state_q == ST_SEC_WAIT && mem_rsp_valid) begin
                done_q  <= 1'b1;
                fault_q <= !rsp_present;
                paddr_q <= rsp_present ? {rsp_frame, vaddr_q[OFF_BITS-1:0]} : '0;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_DIR_REQ) || (state_q == ST_SEC_REQ);
        mem_req_addr  = (state_q == ST_SEC_REQ) ? sec_entry_addr : dir_entry_addr;
        done          = done_q;
        fault         = fault_q;
        paddr         = paddr_q;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_req_ready,
    input logic              mem_rsp_valid,
    input logic              done,
    input logic              fault,
    input logic [ADDR_W-1:0] paddr
);
    logic [1:0] owed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) owed_q <= '0;
        else owed_q <= owed_q + {1'b0, (mem_req_valid && mem_req_ready)}
                              - {1'b0, mem_rsp_valid};
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> owed_q == 2'd0); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_FAULT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done); // R6
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> paddr == '0); // R6
    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R7
    AST_ACCEPT_READS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> mem_req_valid); // R1
    AST_DONE_FOLLOWS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rsp_valid)); // R3
endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .fault         (fault),
    .paddr         (paddr)
);

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done, fault;
    logic [31:0] paddr;

    int checks = 0;
    int failures = 0;

    // memory model state
    int          lat = 0;
    bit          ready_toggle = 1'b0;
    bit          tog = 1'b0;
    bit          pending = 1'b0;
    int          wait_cnt = 0;
    logic [31:0] pend_addr = '0;
    int          total_reads = 0;
    logic [31:0] hist [4];

    logic [31:0] cur_base = '0;

    always #4 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .paddr(paddr)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [9:0] w;
        logic       v;
        w = a[11:2];
        v = (^a[11:2]) ^ a[13];
        return {a[31:12] ^ {w, w}, 11'h000, v};
    endfunction

    // Reactive memory: all decisions at the falling edge
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        tog = ~tog;
        mem_req_ready = ready_toggle ? tog : 1'b1;
        if (pending) begin
            if (wait_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(pend_addr);
                pending       = 1'b0;
            end else begin
                wait_cnt = wait_cnt - 1;
            end
        end else if (rst_n && mem_req_valid && mem_req_ready) begin
            pending   = 1'b1;
            pend_addr = mem_req_addr;
            wait_cnt  = lat;
            hist[total_reads % 4] = mem_req_addr;
            total_reads = total_reads + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One walk starting at a falling edge with the walker idle
    task automatic run_walk(input logic [31:0] va, input bit poke, input bit b2b,
                            input bit wr_base, input logic [31:0] new_base);
        logic [31:0] a1, a2, e1, e2, exp_pa;
        bit          exp_fault;
        int          exp_reads, start;
        string       tag;
        a1 = cur_base + {20'h0, va[31:22], 2'b00};
        e1 = mem_word(a1);
        a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
        e2 = mem_word(a2);
        if (!e1[0]) begin
            exp_fault = 1; exp_reads = 1; exp_pa = '0; tag = "R3";
        end else if (!e2[0]) begin
            exp_fault = 1; exp_reads = 2; exp_pa = '0; tag = "R4";
        end else begin
            exp_fault = 0; exp_reads = 2; exp_pa = {e2[31:12], va[11:0]}; tag = "R5";
        end
        chk(req_ready === 1'b1, b2b ? "R11 ready with done" : "R7 ready when idle", {31'b0, req_ready}, 32'd1);
        start     = total_reads;
        req_valid = 1'b1;
        req_vaddr = va;
        if (wr_base) begin
            base_wr_en   = 1'b1;
            base_wr_data = new_base;
        end
        @(negedge clk);
        req_valid  = 1'b0;
        base_wr_en = 1'b0;
        if (wr_base) cur_base = new_base;
        if (poke) begin
            req_valid = 1'b1;
            req_vaddr = ~va;
            chk(req_ready === 1'b0, "R7 busy not ready", {31'b0, req_ready}, 32'd0);
            @(negedge clk);
            chk(req_ready === 1'b0, "R7 busy not ready", {31'b0, req_ready}, 32'd0);
            req_valid = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        chk(fault === exp_fault, {tag, " fault"}, {31'b0, fault}, {31'b0, exp_fault});
        chk(paddr === exp_pa, {tag, " paddr"}, paddr, exp_pa);
        chk(total_reads - start == exp_reads, {tag, " read count"}, total_reads - start, exp_reads);
        chk(hist[start % 4] === a1, wr_base ? "R8 old base used" : "R1 directory read addr", hist[start % 4], a1);
        if (exp_reads == 2)
            chk(hist[(start + 1) % 4] === a2, "R2 table read addr", hist[(start + 1) % 4], a2);
        if (!b2b) begin
            @(negedge clk);
            chk(done === 1'b0 && fault === 1'b0, "R6 single-cycle pulse", {30'b0, done, fault}, 32'd0);
        end
    endtask

    task automatic set_base(input logic [31:0] b);
        base_wr_en   = 1'b1;
        base_wr_data = b;
        @(negedge clk);
        base_wr_en = 1'b0;
        cur_base   = b;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R10 ready after reset", {31'b0, req_ready}, 32'd1);
        chk(mem_req_valid === 1'b0, "R10 no read after reset", {31'b0, mem_req_valid}, 32'd0);
        chk(done === 1'b0 && fault === 1'b0, "R10 no pulse after reset", {30'b0, done, fault}, 32'd0);

        // R8: reset base of zero
        run_walk(32'h0123_4567, 0, 0, 0, '0);
        run_walk(32'hFFC0_1ABC, 0, 0, 0, '0);

        // full directory sweep, zero latency, back-to-back on odd indices
        set_base(32'h0040_0000);
        for (int d = 0; d < 1024; d++) begin
            logic [9:0] di, si;
            di = 10'(d);
            si = di ^ 10'h2AB;
            run_walk({di, si, 12'(d * 7)}, 0, di[0], 0, '0);
        end

        // latency and toggling ready, table index sweep
        @(negedge clk);
        lat = 2;
        ready_toggle = 1'b1;
        set_base(32'h0080_3000);
        for (int k = 0; k < 256; k++) begin
            logic [9:0] di, si;
            di = 10'(k * 4 + 1);
            si = 10'(k * 3);
            run_walk({di, si, 12'hFFF - 12'(k)}, 0, 0, 0, '0);
        end

        // R7: requests while busy are ignored
        lat = 3;
        ready_toggle = 1'b0;
        for (int k = 0; k < 16; k++)
            run_walk({10'(k * 61), 10'(k * 17), 12'(k)}, 1, 0, 0, '0);

        // R8: base write in the acceptance cycle, then a walk on the new base
        lat = 0;
        run_walk(32'h1234_5678, 0, 0, 1, 32'h00C0_0000);
        run_walk(32'h1234_5678, 0, 0, 0, '0);
        run_walk(32'h8765_4321, 0, 0, 1, 32'h0010_0000);
        run_walk(32'h8765_4321, 0, 0, 0, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule